// File: doc/BRIEF.md
# Lockable PUF/Fuse Key Router

This block delivers secret keys to three consumers over private key buses. Route 0 feeds the secure-storage master-key sink. Routes 1 and 2 feed the unwrap-key inputs of two on-the-fly decryption engines, called A and B. Each route has a one-bit select:
- 0 picks a fixed source. For route 0 this is the fuse-derived device key. For routes 1 and 2 it is a shared 128-bit user key.
- 1 picks the PUF-derived key.

After reset each select takes its default from a fuse. Software can then override a select through a small register port, except on routes whose lock fuse is blown.

A PUF-enable fuse gates every PUF-sourced delivery. A write-one-to-set zeroize control erases the PUF material for good. It drives a sequencer through ST_ERASE into a terminal ST_DEAD state, and after that no PUF-sourced key is ever delivered again until reset. Any route that selects the PUF while the PUF is unusable outputs all zeros and raises its route-error flag.

At startup a load-inline fuse can cause a single automatic key load to the inline encryption engine.

The sequencer has five states:
- ST_BOOT goes to ST_LOAD when the load-inline fuse is set, and to ST_RUN otherwise. In ST_BOOT the select registers are loaded from the fuses.
- ST_LOAD goes to ST_RUN and produces the inline-key strobe.
- ST_RUN goes to ST_ERASE when zeroize is set.
- ST_ERASE goes to ST_DEAD.
- ST_DEAD stays in ST_DEAD.

Top module: `key_route_top`

## Requirements
- R1: Route 0 key output equals `dev_key` when its effective select is 0, and equals `puf_key` when the select is 1 and the PUF is usable.
- R2: Routes 1 and 2 key outputs equal `user_key` when their effective select is 0, and equal `puf_key` when the select is 1 and the PUF is usable.
- R3: After reset each effective select equals its fuse bit. A write to address 0 sets the select of every unlocked route i to `reg_wdata[i]`. Route 0 is bit 0, engine A is bit 1 and engine B is bit 2.
- R4: For a route whose `fuse_lock` bit is 1, writes are ignored and its effective select always equals its `fuse_sel` bit.
- R5: The PUF is usable only when `fuse_puf_en` is 1 and zeroize is clear. A route that selects an unusable PUF outputs all zeros and has its error flag at 1. Otherwise its error flag is 0.
- R6: Writing address 1 with bit 0 set sets the zeroize flag. Writing bit 0 as 0 has no effect. The flag stays set until reset. Once it is set, the sequencer passes through ST_ERASE to ST_DEAD and remains there.
- R7: Each route's valid strobe is high for exactly one cycle, in the cycle its key output takes a new value. It stays low while the key output is unchanged.
- R8: With `fuse_load_inline` = 1, one `inline_vld` pulse carrying `user_key` occurs after reset. With `fuse_load_inline` = 0, no pulse occurs.
- R9: Reading address 0 returns the effective selects in bits [2:0] and the lock fuses in bits [5:3]. Address 1 returns the zeroize flag in bit 0 and the ST_DEAD indication in bit 1. Every other bit and address reads 0, so no key material is ever returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_sel | input | 3 | Default select per route |
| fuse_lock | input | 3 | Per-route lock against software select writes |
| fuse_puf_en | input | 1 | PUF enable fuse |
| fuse_load_inline | input | 1 | Enables the startup inline-engine key load |
| dev_key | input | KEY_W | Fuse-derived device key (fixed source for route 0) |
| user_key | input | KEY_W | User key (fixed source for routes 1 and 2, and the inline load) |
| puf_key | input | KEY_W | PUF-derived key |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| mk_key | output | KEY_W | Master-key bus |
| mk_vld | output | 1 | Master-key change strobe |
| mk_err | output | 1 | Master-key route error |
| ea_key | output | KEY_W | Engine A unwrap-key bus |
| ea_vld | output | 1 | Engine A change strobe |
| ea_err | output | 1 | Engine A route error |
| eb_key | output | KEY_W | Engine B unwrap-key bus |
| eb_vld | output | 1 | Engine B change strobe |
| eb_err | output | 1 | Engine B route error |
| inline_key | output | KEY_W | Inline-engine key |
| inline_vld | output | 1 | Inline-engine load strobe |

## Verification
Timing of each result, counting clock edges from a stimulus:
- Read data is combinational. A register write is visible on read-back one edge after it is sampled.
- A key or error change from a register write appears one edge later still, that is, on the second edge.
- A change on the key inputs reaches the key outputs on the first edge.
- After zeroize is sampled, the read-back shows ST_DEAD on the third edge.
- The inline strobe appears on the second edge after reset is released.

Each operation in the bench is driven on a falling edge and followed by a window of four falling-edge samples. The strobes are counted across that whole window, so every expected pulse falls inside it. Steady values are compared only at the end of the window.

// File: rtl/kr_pkg.sv
package kr_pkg;
    localparam int N_ROUTES = 3;
    localparam int ROUTE_MK = 0;
    localparam logic [1:0] ADDR_SEL = 2'd0;
    localparam logic [1:0] ADDR_CTL = 2'd1;

    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_RUN   = 3'd2,
        ST_ERASE = 3'd3,
        ST_DEAD  = 3'd4
    } kr_state_e;
endpackage

// File: rtl/kr_ctl_regs.sv
module kr_ctl_regs
    import kr_pkg::*;
#(
    parameter int NR    = N_ROUTES,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_fuse,
    input  logic [NR-1:0]    fuse_sel,
    input  logic [NR-1:0]    fuse_lock,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             dead,
    output logic [NR-1:0]    eff_sel,
    output logic             zero_q,
    output logic [REG_W-1:0] reg_rdata
);
    logic [NR-1:0] sel_q;
    logic          wr_sel;
    logic          wr_ctl;
    logic          wdata_unused;

    assign wr_sel       = reg_wr && (reg_addr == ADDR_SEL) && !load_fuse;
    assign wr_ctl       = reg_wr && (reg_addr == ADDR_CTL);
    assign wdata_unused = ^reg_wdata[REG_W-1:NR];

    for (genvar i = 0; i < NR; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[i] <= 1'b0;
            end else if (load_fuse) begin
                sel_q[i] <= fuse_sel[i];
            end else if (wr_sel && !fuse_lock[i]) begin
                sel_q[i] <= reg_wdata[i];
            end
        end
        assign eff_sel[i] = fuse_lock[i] ? fuse_sel[i] : sel_q[i];
    end

    // zeroize: write-one-to-set, cleared only by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_q <= 1'b0;
        end else if (wr_ctl && reg_wdata[0]) begin
            zero_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_SEL: begin
                reg_rdata[NR-1:0]    = eff_sel;
                reg_rdata[2*NR-1:NR] = fuse_lock;
            end
            ADDR_CTL: begin
                reg_rdata[0] = zero_q;
                reg_rdata[1] = dead;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kr_seq.sv
module kr_seq
    import kr_pkg::*;
#(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_load_inline,
    input  logic             fuse_puf_en,
    input  logic             zero_q,
    input  logic [KEY_W-1:0] user_key,
    output kr_state_e        state_q,
    output logic             puf_ok,
    output logic [KEY_W-1:0] inline_key,
    output logic             inline_vld
);
    kr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = fuse_load_inline ? ST_LOAD : ST_RUN;
            ST_LOAD:  state_d = ST_RUN;
            ST_RUN:   state_d = zero_q ? ST_ERASE : ST_RUN;
            ST_ERASE: state_d = ST_DEAD;
            ST_DEAD:  state_d = ST_DEAD;
            default:  state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inline_vld <= 1'b0;
            inline_key <= '0;
        end else begin
            inline_vld <= (state_q == ST_LOAD);
            if (state_q == ST_LOAD) begin
                inline_key <= user_key;
            end
        end
    end

    assign puf_ok = fuse_puf_en && !zero_q
                    && (state_q != ST_ERASE) && (state_q != ST_DEAD);
endmodule

// File: rtl/kr_route.sv
module kr_route #(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             puf_ok,
    input  logic [KEY_W-1:0] fixed_key,
    input  logic [KEY_W-1:0] puf_key,
    output logic [KEY_W-1:0] key_q,
    output logic             vld_q,
    output logic             err_q
);
    logic [KEY_W-1:0] key_d;

    always_comb begin
        if (!sel) begin
            key_d = fixed_key;
        end else if (puf_ok) begin
            key_d = puf_key;
        end else begin
            key_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            vld_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            key_q <= key_d;
            vld_q <= (key_d != key_q);
            err_q <= sel && !puf_ok;
        end
    end
endmodule

// File: rtl/key_route_top.sv
module key_route_top
    import kr_pkg::*;
#(
    parameter int KEY_W = 128,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fuse_sel,
    input  logic [2:0]       fuse_lock,
    input  logic             fuse_puf_en,
    input  logic             fuse_load_inline,
    input  logic [KEY_W-1:0] dev_key,
    input  logic [KEY_W-1:0] user_key,
    input  logic [KEY_W-1:0] puf_key,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [KEY_W-1:0] mk_key,
    output logic             mk_vld,
    output logic             mk_err,
    output logic [KEY_W-1:0] ea_key,
    output logic             ea_vld,
    output logic             ea_err,
    output logic [KEY_W-1:0] eb_key,
    output logic             eb_vld,
    output logic             eb_err,
    output logic [KEY_W-1:0] inline_key,
    output logic             inline_vld
);
    localparam int NR = N_ROUTES;

    kr_state_e        state_q;
    logic [NR-1:0]    eff_sel;
    logic             zero_q;
    logic             puf_ok;
    logic [KEY_W-1:0] r_key [NR];
    logic [NR-1:0]    r_vld;
    logic [NR-1:0]    r_err;

    kr_ctl_regs #(.NR(NR), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_fuse (state_q == ST_BOOT),
        .fuse_sel  (fuse_sel),
        .fuse_lock (fuse_lock),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .dead      (state_q == ST_DEAD),
        .eff_sel   (eff_sel),
        .zero_q    (zero_q),
        .reg_rdata (reg_rdata)
    );

    kr_seq #(.KEY_W(KEY_W)) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .fuse_load_inline (fuse_load_inline),
        .fuse_puf_en      (fuse_puf_en),
        .zero_q           (zero_q),
        .user_key         (user_key),
        .state_q          (state_q),
        .puf_ok           (puf_ok),
        .inline_key       (inline_key),
        .inline_vld       (inline_vld)
    );

    for (genvar i = 0; i < NR; i++) begin : g_route
        kr_route #(.KEY_W(KEY_W)) u_route (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (eff_sel[i]),
            .puf_ok    (puf_ok),
            .fixed_key ((i == ROUTE_MK) ? dev_key : user_key),
            .puf_key   (puf_key),
            .key_q     (r_key[i]),
            .vld_q     (r_vld[i]),
            .err_q     (r_err[i])
        );
    end

    assign mk_key = r_key[0];
    assign mk_vld = r_vld[0];
    assign mk_err = r_err[0];
    assign ea_key = r_key[1];
    assign ea_vld = r_vld[1];
    assign ea_err = r_err[1];
    assign eb_key = r_key[2];
    assign eb_vld = r_vld[2];
    assign eb_err = r_err[2];
endmodule

// File: rtl/kr_checker.sv
module kr_checker
    import kr_pkg::*;
#(
    parameter int KEY_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       fuse_lock,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [2:0]       eff_sel,
    input logic             zero_q,
    input kr_state_e        state_q,
    input logic [KEY_W-1:0] mk_key,
    input logic             mk_vld,
    input logic             mk_err,
    input logic [KEY_W-1:0] ea_key,
    input logic             ea_vld,
    input logic             ea_err,
    input logic [KEY_W-1:0] eb_key,
    input logic             eb_vld,
    input logic             eb_err,
    input logic             inline_vld
);
    AST_LOCKED_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_SEL && state_q != ST_BOOT)
        |=> (((eff_sel ^ $past(eff_sel)) & fuse_lock) == 3'b000)); // R4
    AST_MK_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mk_err |-> (mk_key == '0)); // R5
    AST_EA_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ea_err |-> (ea_key == '0)); // R5
    AST_EB_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        eb_err |-> (eb_key == '0)); // R5
    AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |=> zero_q); // R6
    AST_DEAD_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEAD) |=> (state_q == ST_DEAD)); // R6
    AST_MK_VLD_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mk_vld == (mk_key != $past(mk_key))); // R7
    AST_EA_VLD_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ea_vld == (ea_key != $past(ea_key))); // R7
    AST_EB_VLD_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        eb_vld == (eb_key != $past(eb_key))); // R7
    AST_INLINE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        inline_vld |=> !inline_vld); // R8
endmodule

bind key_route_top kr_checker #(.KEY_W(KEY_W)) u_kr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fuse_lock  (fuse_lock),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .eff_sel    (eff_sel),
    .zero_q     (zero_q),
    .state_q    (state_q),
    .mk_key     (mk_key),
    .mk_vld     (mk_vld),
    .mk_err     (mk_err),
    .ea_key     (ea_key),
    .ea_vld     (ea_vld),
    .ea_err     (ea_err),
    .eb_key     (eb_key),
    .eb_vld     (eb_vld),
    .eb_err     (eb_err),
    .inline_vld (inline_vld)
);

// File: tb/test_key_route_top.sv
`timescale 1ns/1ps
module test_key_route_top;
    localparam int KW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    fuse_sel = '0, fuse_lock = '0;
    logic          fuse_puf_en = 1'b0, fuse_load_inline = 1'b0;
    logic [KW-1:0] dev_key = '0, user_key = '0, puf_key = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [KW-1:0] mk_key, ea_key, eb_key, inline_key;
    logic          mk_vld, ea_vld, eb_vld, mk_err, ea_err, eb_err, inline_vld;

    int n_vec = 0;
    int n_bad = 0;
    logic [2:0] m_sel;
    logic       m_zero;

    always #2.5 clk = ~clk;

    key_route_top i_key_route_top (
        .clk(clk), .rst_n(rst_n), .fuse_sel(fuse_sel), .fuse_lock(fuse_lock),
        .fuse_puf_en(fuse_puf_en), .fuse_load_inline(fuse_load_inline),
        .dev_key(dev_key), .user_key(user_key), .puf_key(puf_key),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mk_key(mk_key), .mk_vld(mk_vld), .mk_err(mk_err),
        .ea_key(ea_key), .ea_vld(ea_vld), .ea_err(ea_err),
        .eb_key(eb_key), .eb_vld(eb_vld), .eb_err(eb_err),
        .inline_key(inline_key), .inline_vld(inline_vld)
    );

    task automatic chk(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [KW-1:0] exp_key(input int r);
        logic ok;
        ok = fuse_puf_en && !m_zero;
        if (!m_sel[r]) return (r == 0) ? dev_key : user_key;
        return ok ? puf_key : '0;
    endfunction

    function automatic logic exp_err(input int r);
        return m_sel[r] && !(fuse_puf_en && !m_zero);
    endfunction

    task automatic check_state();
        chk("R1 master key", mk_key, exp_key(0));
        chk("R2 engine A key", ea_key, exp_key(1));
        chk("R2 engine B key", eb_key, exp_key(2));
        chk("R5 error flags", {mk_err, ea_err, eb_err}, {exp_err(0), exp_err(1), exp_err(2)});
        reg_addr = 2'd0; #0.1;
        chk("R3 R4 select/lock readback", reg_rdata, {2'b00, fuse_lock, m_sel});
        reg_addr = 2'd1; #0.1;
        chk("R6 R9 control readback", reg_rdata, {6'd0, m_zero, m_zero});
        reg_addr = 2'd2; #0.1;
        chk("R9 unused address", reg_rdata, '0);
        reg_addr = 2'd3; #0.1;
        chk("R9 unused address", reg_rdata, '0);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_sel  = fuse_sel;
        m_zero = 1'b0;
        begin
            int pulses = 0;
            logic [KW-1:0] seen = '0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (inline_vld) begin
                    pulses++;
                    seen = inline_key;
                end
            end
            chk("R8 inline pulse count", pulses, fuse_load_inline ? 1 : 0);
            if (fuse_load_inline) chk("R8 inline key", seen, user_key);
        end
        check_state();
    endtask

    // kind: 0 write sel, 1 change fixed keys, 2 change puf key, 3 write ctl
    task automatic do_op(input int kind, input logic [7:0] wd);
        logic [KW-1:0] p0, p1, p2;
        int c0 = 0, c1 = 0, c2 = 0;
        p0 = exp_key(0); p1 = exp_key(1); p2 = exp_key(2);
        case (kind)
            0: begin
                reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = wd;
                m_sel = (fuse_lock & fuse_sel) | (~fuse_lock & wd[2:0]);
            end
            1: begin
                dev_key  = {$urandom, $urandom, $urandom, $urandom};
                user_key = {$urandom, $urandom, $urandom, $urandom};
            end
            2: puf_key = {$urandom, $urandom, $urandom, $urandom};
            default: begin
                reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = wd;
                if (wd[0]) m_zero = 1'b1;
            end
        endcase
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            c0 += int'(mk_vld); c1 += int'(ea_vld); c2 += int'(eb_vld);
            if (k == 0) reg_wr = 1'b0;
        end
        chk("R7 master strobe count", c0, (p0 != exp_key(0)) ? 1 : 0);
        chk("R7 engine A strobe count", c1, (p1 != exp_key(1)) ? 1 : 0);
        chk("R7 engine B strobe count", c2, (p2 != exp_key(2)) ? 1 : 0);
        check_state();
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int e = 0; e < 40; e++) begin
            dev_key  = {$urandom, $urandom, $urandom, $urandom};
            user_key = {$urandom, $urandom, $urandom, $urandom};
            puf_key  = {$urandom, $urandom, $urandom, $urandom};
            if (e == 0) begin
                // directed: master locked to PUF, engines software-controlled
                fuse_sel = 3'b101; fuse_lock = 3'b001;
                fuse_puf_en = 1'b1; fuse_load_inline = 1'b1;
            end else if (e == 1) begin
                // directed: PUF disabled, every route locked on PUF
                fuse_sel = 3'b111; fuse_lock = 3'b111;
                fuse_puf_en = 1'b0; fuse_load_inline = 1'b0;
            end else begin
                fuse_sel = 3'($urandom_range(0, 7));
                fuse_lock = 3'($urandom_range(0, 7));
                fuse_puf_en = 1'($urandom_range(0, 1));
                fuse_load_inline = 1'($urandom_range(0, 1));
            end
            apply_reset();
            if (e == 0) begin
                do_op(0, 8'h00);   // R4: route 0 keeps PUF, R3: routes 1,2 to user key
                do_op(0, 8'h06);   // R3: engines back to PUF
                do_op(3, 8'hFE);   // R6: bit0 clear has no effect
                do_op(3, 8'h01);   // R6: zeroize
                do_op(3, 8'h00);   // R6: still set
                do_op(2, 8'h00);   // R5: PUF key change not delivered
                do_op(0, 8'h00);   // R2: engines back to user key after zeroize
            end else if (e == 1) begin
                do_op(0, 8'h00);   // R4: all locked
                do_op(2, 8'h00);   // R5: zeros remain
                do_op(1, 8'h00);
            end else begin
                for (int k = 0; k < 12; k++) begin
                    int r;
                    r = $urandom_range(0, 15);
                    if (r < 6)       do_op(0, 8'($urandom));
                    else if (r < 10) do_op(1, 8'h00);
                    else if (r < 14) do_op(2, 8'h00);
                    else             do_op(3, 8'($urandom));
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule